// File: doc/BRIEF.md
# Word/Byte ALU with Condition Codes

This is the purely combinational arithmetic and logic stage of a 16-bit processor datapath. It takes two operands that have already been fetched: a source and a destination. It also takes an operation code, a byte/word selector and the current four condition flags. From these it produces the result, a write-back strobe and the updated flags in the same cycle. Instruction decode and operand fetch sit upstream. Storing the result sits downstream and is gated by the write-back strobe.

It covers the two-operand family: move, compare, bit test, bit clear, bit set, add and subtract. It also covers the one-operand family: clear, complement, increment, decrement, negate, add/subtract carry, test, rotates through carry, arithmetic shifts, byte swap and sign extend. Internally, two copies of the same datapath lane run side by side, one at full width and one at half width. The byte selector picks which lane supplies the outputs.

Top module: `wb_alu`

## Requirements
- R1: Flags are packed N=bit 3, Z=bit 2, V=bit 1, C=bit 0 on both flag ports. The op_i codes are 0 MOV, 1 CMP, 2 BIT, 3 BIC, 4 BIS, 5 ADD, 6 SUB, 7 CLR, 8 COM, 9 INC, 10 DEC, 11 NEG, 12 ADC, 13 SBC, 14 TST, 15 ROR, 16 ROL, 17 ASR, 18 ASL, 19 SWAB, 20 SXT. Codes 21 to 31 return the destination unchanged, leave all flags unchanged and deassert write-back.
- R2: The write-back strobe is low for CMP, BIT, TST and the unused codes, and high for every other operation.
- R3: MOV yields the source, BIT yields source AND destination, BIC yields destination AND NOT source, and BIS yields source OR destination. All four set N and Z from the result, clear V and keep C.
- R4: CMP computes source minus destination. N and Z come from that difference, V flags signed overflow, and C is set when the source is below the destination as unsigned numbers.
- R5: ADD yields destination plus source, with C as the carry out. SUB yields destination minus source, with C as the unsigned borrow. Both set V on signed overflow and always work on the full word, whatever byte_i says.
- R6: CLR yields zero with flags N=0 Z=1 V=0 C=0. COM inverts every bit, clears V and sets C. TST passes the destination through, sets N and Z from it, and clears V and C.
- R7: INC and DEC add or subtract one. V is set only when the input is the largest positive value (INC) or the most negative value (DEC). C is left unchanged.
- R8: NEG yields zero minus the operand, with V set only for the most negative input and C set for any nonzero result. ADC adds the incoming C. SBC subtracts the incoming C. ADC sets C on a carry out and SBC sets C on a borrow. Both set V on signed overflow.
- R9: ROR shifts right with the old C entering the top bit and bit 0 leaving into C. ROL shifts left with the old C entering bit 0 and the top bit leaving into C.
- R10: ASR shifts right while replicating the top bit, with bit 0 leaving into C. ASL shifts left, fills bit 0 with zero, and sends the top bit into C.
- R11: For ROR, ROL, ASR and ASL, V after the operation equals N XOR C after the operation.
- R12: SWAB exchanges the two bytes of the full word regardless of byte_i. N and Z come from the low byte of the result, and V and C are cleared.
- R13: SXT yields all ones when the incoming N is set and all zeros otherwise, always at full width. N is unchanged, Z is the inverse of N, V is cleared and C is unchanged.
- R14: With byte_i high, every operation except ADD, SUB, SWAB and SXT works on the low 8 bits. N is bit 7, Z tests the low byte only, and carry, overflow and shift boundaries are taken at 8 bits. The upper byte of the result repeats the destination's upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1) |
| byte_i | input | 1 | Byte-wide operation when high |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Current N, Z, V, C |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 4 | Updated N, Z, V, C |

## Verification
The checker's properties are sampled immediately from combinational outputs. They therefore assume two-state inputs that change only between evaluations, with no X or Z on op_i or the flags. The bench respects this by driving every input just after a clock edge and comparing only at the following falling edge. It sweeps all 32 operation codes, both widths, a spread of incoming flag patterns and operand corners around zero, the sign boundaries and all ones, then adds random vectors.

// File: rtl/wb_alu_pkg.sv
package wb_alu_pkg;
  typedef enum logic [4:0] {
    OP_MOV  = 5'd0,
    OP_CMP  = 5'd1,
    OP_BIT  = 5'd2,
    OP_BIC  = 5'd3,
    OP_BIS  = 5'd4,
    OP_ADD  = 5'd5,
    OP_SUB  = 5'd6,
    OP_CLR  = 5'd7,
    OP_COM  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_NEG  = 5'd11,
    OP_ADC  = 5'd12,
    OP_SBC  = 5'd13,
    OP_TST  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ROL  = 5'd16,
    OP_ASR  = 5'd17,
    OP_ASL  = 5'd18,
    OP_SWAB = 5'd19,
    OP_SXT  = 5'd20
  } alu_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/wb_alu_arith.sv
module wb_alu_arith
  import wb_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_i,
  output logic [W-1:0]   res_o,
  output logic           v_o,
  output logic           c_o
);
  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   sum;

  // every arithmetic op folds into x + y + cin
  always_comb begin
    x = b_i; y = '0; cin = 1'b0;
    case (op_i)
      OP_ADD: begin x = b_i;  y = a_i;  cin = 1'b0; end
      OP_SUB: begin x = b_i;  y = ~a_i; cin = 1'b1; end
      OP_CMP: begin x = a_i;  y = ~b_i; cin = 1'b1; end
      OP_INC: begin x = b_i;  y = '0;   cin = 1'b1; end
      OP_DEC: begin x = b_i;  y = '1;   cin = 1'b0; end
      OP_NEG: begin x = '0;   y = ~b_i; cin = 1'b1; end
      OP_ADC: begin x = b_i;  y = '0;   cin = c_i;  end
      OP_SBC: begin x = b_i;  y = '1;   cin = ~c_i; end
      default: ;
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign res_o = sum[W-1:0];
  assign v_o   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADC:                 c_o = sum[W];
      OP_SUB, OP_CMP, OP_NEG, OP_SBC: c_o = ~sum[W];
      default:                        c_o = c_i;
    endcase
  end
endmodule

// File: rtl/wb_alu_shift.sv
module wb_alu_shift
  import wb_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = b_i;
    c_o   = c_i;
    case (op_i)
      OP_ROR: begin res_o = {c_i, b_i[W-1:1]};      c_o = b_i[0];   end
      OP_ROL: begin res_o = {b_i[W-2:0], c_i};      c_o = b_i[W-1]; end
      OP_ASR: begin res_o = {b_i[W-1], b_i[W-1:1]}; c_o = b_i[0];   end
      OP_ASL: begin res_o = {b_i[W-2:0], 1'b0};     c_o = b_i[W-1]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/wb_alu_logic.sv
module wb_alu_logic
  import wb_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         n_i,
  output logic [W-1:0] res_o
);
  localparam int H = W / 2;

  always_comb begin
    case (op_i)
      OP_MOV:  res_o = a_i;
      OP_BIT:  res_o = a_i & b_i;
      OP_BIC:  res_o = b_i & ~a_i;
      OP_BIS:  res_o = a_i | b_i;
      OP_CLR:  res_o = '0;
      OP_COM:  res_o = ~b_i;
      OP_SWAB: res_o = {b_i[H-1:0], b_i[W-1:H]};
      OP_SXT:  res_o = {W{n_i}};
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/wb_alu_lane.sv
module wb_alu_lane
  import wb_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o
);
  localparam int H = W / 2;

  logic [W-1:0] ar_res, sh_res, lg_res;
  logic         ar_v, ar_c, sh_c;
  logic         n, z, v, c;
  logic         is_shift;

  wb_alu_arith #(.W(W)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(flags_i[FLG_C]),
    .res_o(ar_res), .v_o(ar_v), .c_o(ar_c)
  );

  wb_alu_shift #(.W(W)) u_shift (
    .op_i(op_i), .b_i(b_i), .c_i(flags_i[FLG_C]),
    .res_o(sh_res), .c_o(sh_c)
  );

  wb_alu_logic #(.W(W)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .n_i(flags_i[FLG_N]),
    .res_o(lg_res)
  );

  assign is_shift = op_i inside {OP_ROR, OP_ROL, OP_ASR, OP_ASL};

  always_comb begin
    res_o = b_i;
    n = flags_i[FLG_N];
    z = flags_i[FLG_Z];
    v = flags_i[FLG_V];
    c = flags_i[FLG_C];
    case (op_i)
      OP_MOV, OP_BIT, OP_BIC, OP_BIS: begin res_o = lg_res; v = 1'b0; end
      OP_CLR, OP_TST, OP_SWAB: begin res_o = lg_res; v = 1'b0; c = 1'b0; end
      OP_COM: begin res_o = lg_res; v = 1'b0; c = 1'b1; end
      OP_SXT: begin res_o = lg_res; v = 1'b0; end
      OP_CMP, OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG, OP_ADC, OP_SBC: begin
        res_o = ar_res; v = ar_v; c = ar_c;
      end
      OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin res_o = sh_res; c = sh_c; end
      default: ;
    endcase
    if (op_i <= OP_SXT) begin
      n = res_o[W-1];
      z = ~|res_o;
    end
    if (op_i == OP_SWAB) begin
      n = res_o[H-1];
      z = ~|res_o[H-1:0];
    end
    if (op_i == OP_SXT) begin
      n = flags_i[FLG_N];
      z = ~flags_i[FLG_N];
    end
    if (is_shift) v = n ^ c;
    flags_o = {n, z, v, c};
  end
endmodule

// File: rtl/wb_alu.sv
module wb_alu
  import wb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [4:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [3:0]        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e            op;
  logic               use_byte;
  logic [DATA_W-1:0]  wrd_res;
  logic [HALF_W-1:0]  byt_res;
  logic [3:0]         wrd_flg, byt_flg;

  assign op       = alu_op_e'(op_i);
  assign use_byte = byte_i && !(op inside {OP_ADD, OP_SUB, OP_SWAB, OP_SXT});

  wb_alu_lane #(.W(DATA_W)) u_lane_word (
    .op_i(op), .a_i(src_i), .b_i(dst_i), .flags_i(flags_i),
    .res_o(wrd_res), .flags_o(wrd_flg)
  );

  wb_alu_lane #(.W(HALF_W)) u_lane_byte (
    .op_i(op), .a_i(src_i[HALF_W-1:0]), .b_i(dst_i[HALF_W-1:0]), .flags_i(flags_i),
    .res_o(byt_res), .flags_o(byt_flg)
  );

  assign res_o   = use_byte ? {dst_i[DATA_W-1:HALF_W], byt_res} : wrd_res;
  assign flags_o = use_byte ? byt_flg : wrd_flg;
  assign wr_o    = (op <= OP_SXT) && !(op inside {OP_CMP, OP_BIT, OP_TST});
endmodule

// File: rtl/wb_alu_chk.sv
module wb_alu_chk
  import wb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic [4:0]        op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_o,
  input logic [3:0]        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic is_shift, no_wb, logic_op, wide_only, unused_op;

  assign is_shift  = op_i inside {OP_ROR, OP_ROL, OP_ASR, OP_ASL};
  assign no_wb     = op_i inside {OP_CMP, OP_BIT, OP_TST};
  assign logic_op  = op_i inside {OP_MOV, OP_BIT, OP_BIC, OP_BIS};
  assign wide_only = op_i inside {OP_ADD, OP_SUB, OP_SWAB, OP_SXT};
  assign unused_op = op_i > OP_SXT;

  always_comb begin
    AST_NO_WRITEBACK: assert (!no_wb || !wr_o) else $error("wb on no-store op"); // R2
    AST_SHIFT_V: assert (!is_shift || (flags_o[FLG_V] == (flags_o[FLG_N] ^ flags_o[FLG_C])))
      else $error("shift V"); // R11
    AST_LOGIC_FLAGS: assert (!logic_op || (!flags_o[FLG_V] && flags_o[FLG_C] == flags_i[FLG_C]))
      else $error("logic flags"); // R3
    AST_INC_DEC_KEEP_C: assert (!(op_i inside {OP_INC, OP_DEC}) || flags_o[FLG_C] == flags_i[FLG_C])
      else $error("inc/dec C"); // R7
    AST_CLR_FLAGS: assert (op_i != OP_CLR || flags_o == 4'b0100) else $error("clr flags"); // R6
    AST_BYTE_HIGH_KEEP: assert (!(byte_i && !wide_only) || res_o[DATA_W-1:HALF_W] == dst_i[DATA_W-1:HALF_W])
      else $error("byte upper"); // R14
    AST_UNUSED_OP: assert (!unused_op || (res_o == dst_i && flags_o == flags_i && !wr_o))
      else $error("unused op %0d src %h", op_i, src_i); // R1
  end
endmodule

bind wb_alu wb_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i), .flags_i(flags_i),
  .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o)
);

// File: tb/wb_alu_bench.sv
`timescale 1ns/1ps
module wb_alu_bench;
  import wb_alu_pkg::*;

  logic        clk = 1'b0;
  logic [4:0]  op;
  logic        byt;
  logic [15:0] src, dst;
  logic [3:0]  flg_in;
  logic [15:0] res;
  logic        wr;
  logic [3:0]  flg_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wb_alu u_wb_alu (
    .op_i(op), .byte_i(byt), .src_i(src), .dst_i(dst), .flags_i(flg_in),
    .res_o(res), .wr_o(wr), .flags_o(flg_out)
  );

  function automatic int sx(int x, int top);
    return (x & top) != 0 ? x - 2 * top : x;
  endfunction

  function automatic bit ovf(int val, int top);
    return (val < -top) || (val > top - 1);
  endfunction

  // returns {wr, N, Z, V, C, result}
  function automatic logic [20:0] model(int o, bit b, int s, int d, logic [3:0] f);
    int w, m, top, ds, ss, r;
    bit n, z, v, c, we, cin, nz;
    bit wide = (o == 5) || (o == 6) || (o == 19) || (o == 20);
    w = (b && !wide) ? 8 : 16;
    m = (1 << w) - 1;
    top = 1 << (w - 1);
    ds = d & m; ss = s & m;
    n = f[3]; z = f[2]; v = f[1]; c = f[0]; cin = f[0];
    we = 1; nz = 1; r = ds;
    case (o)
      0: begin r = ss; v = 0; end
      1: begin r = (ss - ds) & m; v = ovf(sx(ss, top) - sx(ds, top), top); c = ss < ds; we = 0; end
      2: begin r = ss & ds; v = 0; we = 0; end
      3: begin r = ds & ~ss & m; v = 0; end
      4: begin r = ds | ss; v = 0; end
      5: begin r = (ds + ss) & m; v = ovf(sx(ds, top) + sx(ss, top), top); c = (ds + ss) > m; end
      6: begin r = (ds - ss) & m; v = ovf(sx(ds, top) - sx(ss, top), top); c = ds < ss; end
      7: begin r = 0; v = 0; c = 0; end
      8: begin r = ~ds & m; v = 0; c = 1; end
      9: begin r = (ds + 1) & m; v = ds == top - 1; end
      10: begin r = (ds - 1) & m; v = ds == top; end
      11: begin r = (0 - ds) & m; v = ds == top; c = ds != 0; end
      12: begin r = (ds + int'(cin)) & m; v = cin && ds == top - 1; c = cin && ds == m; end
      13: begin r = (ds - int'(cin)) & m; v = cin && ds == top; c = cin && ds == 0; end
      14: begin r = ds; v = 0; c = 0; we = 0; end
      15: begin r = (ds >> 1) | (cin ? top : 0); c = ds[0]; end
      16: begin r = ((ds << 1) & m) | int'(cin); c = (ds & top) != 0; end
      17: begin r = (ds >> 1) | (ds & top); c = ds[0]; end
      18: begin r = (ds << 1) & m; c = (ds & top) != 0; end
      19: begin r = ((ds & 255) << 8) | (ds >> 8); v = 0; c = 0; nz = 0;
                n = (r & 128) != 0; z = (r & 255) == 0; end
      20: begin r = f[3] ? 65535 : 0; v = 0; nz = 0; z = !f[3]; end
      default: begin we = 0; nz = 0; r = d & 65535; end
    endcase
    if (nz) begin n = (r & top) != 0; z = r == 0; end
    if (o >= 15 && o <= 18) v = n ^ c;
    if (w == 8 && o <= 20) r = (d & 16'hFF00) | r;
    return {we, n, z, v, c, 16'(r)};
  endfunction

  function automatic string tag(int o);
    case (o)
      0, 2, 3, 4: return "R3";
      1: return "R4";
      5, 6: return "R5";
      7, 8, 14: return "R6";
      9, 10: return "R7";
      11, 12, 13: return "R8";
      15, 16: return "R9";
      17, 18: return "R10";
      19: return "R12";
      20: return "R13";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [15:0] corner(int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h007F;
      3: return 16'h0080; 4: return 16'h00FF; 5: return 16'h0100;
      6: return 16'h7FFF; 7: return 16'h8000; default: return 16'hFFFF;
    endcase
  endfunction

  task automatic apply(int o, bit b, logic [15:0] s, logic [15:0] d, logic [3:0] f);
    logic [20:0] e;
    string t;
    @(posedge clk); #1;
    op = 5'(o); byt = b; src = s; dst = d; flg_in = f;
    @(negedge clk);
    e = model(o, b, int'(s), int'(d), f);
    t = (b && o <= 20) ? {tag(o), "/R14"} : tag(o);
    vectors++;
    if (res !== e[15:0]) begin
      fails++;
      $display("FAIL %s result op=%0d byte=%0b s=%h d=%h f=%b: got %h exp %h", t, o, b, s, d, f, res, e[15:0]);
    end
    if (wr !== e[20]) begin
      fails++;
      $display("FAIL R2 write-back op=%0d: got %0b exp %0b", o, wr, e[20]);
    end
    if (flg_out !== e[19:16]) begin
      fails++;
      $display("FAIL %s%s flags op=%0d byte=%0b s=%h d=%h f=%b: got %b exp %b",
               t, (o >= 15 && o <= 18) ? "/R11" : "", o, b, s, d, f, flg_out, e[19:16]);
    end
  endtask

  initial begin
    op = '0; byt = 1'b0; src = '0; dst = '0; flg_in = '0;
    // idle inputs (MOV of zero): zero result, write-back, Z only (R3)
    apply(0, 1'b0, 16'h0000, 16'h0000, 4'b0000);
    // operation sweep over corners, both widths, several flag patterns
    for (int o = 0; o < 32; o++)
      for (int b = 0; b < 2; b++)
        for (int fi = 0; fi < 16; fi += 3)
          for (int di = 0; di < 9; di++)
            for (int si = 0; si < 9; si++)
              apply(o, b[0], corner(si), corner(di), 4'(fi));
    // random mix
    for (int k = 0; k < 4000; k++)
      apply(int'($urandom_range(0, 31)), 1'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule